// File: doc/BRIEF.md
# SDRAM Command and Address Formatter

This block turns abstract memory requests into the pin-level command pattern of a four-bank, 32-bit synchronous DRAM. A request names an operation, a bank, a row or mode word, a column and an auto-precharge flag. The block drives the active-low chip select, row strobe, column strobe and write enable, the 11-bit shared address bus and the 2-bit bank select. Each request is placed on the address lines in the layout the device expects for that command.

All outputs come from registers clocked on the rising edge, so a request accepted at one edge appears on the pins right after that edge. The request side uses a valid/ready handshake. Once reset is released, ready stays high and one command can be issued every cycle. When no request is valid, the block emits a no-operation command. Checking the timing between commands and data transfer is left to the controller that feeds this block.

Top module: `sdram_cmd_fmt`

## Requirements
- R1: While rst_n is low at a rising edge, the block deselects the device: cs_n, ras_n, cas_n and we_n are high, addr and ba are 0, and req_ready is low.
- R2: A cycle with req_valid low, or a valid request with op code 0 (no-operation), produces cs_n low with ras_n, cas_n and we_n high, and addr and ba at 0.
- R3: Op code 1 (activate) produces ras_n low with cas_n and we_n high. addr carries the full 11-bit req_row and ba carries req_bank.
- R4: Op code 2 (read) produces cas_n low with ras_n and we_n high. addr[7:0] carries req_col, addr[10] carries req_ap, addr[9:8] is 0 and ba carries req_bank.
- R5: Op code 3 (write) produces cas_n and we_n low with ras_n high. The address and bank layout is the same as for a read.
- R6: Op code 4 (precharge one bank) produces ras_n and we_n low with cas_n high. addr is 0, so addr[10] is low, and ba carries req_bank.
- R7: Op code 5 (precharge all) produces ras_n and we_n low with cas_n high. addr[10] is 1, every other address bit is 0, and ba is 0.
- R8: Op code 6 (auto refresh) produces ras_n and cas_n low with we_n high, and addr and ba at 0.
- R9: Op code 7 (mode set) drives ras_n, cas_n and we_n all low. addr carries req_row as the mode word and ba is 0.
- R10: A request accepted at a rising edge appears on the pins right after that same edge. From the first edge after reset release, req_ready is high and back-to-back requests each appear in consecutive cycles.
- R11: Request fields that a command does not use have no effect on the pins. These are the column and auto-precharge flag on activate and mode set, the row on read and write, and every field on refresh and precharge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_op | input | 3 | Operation code (0 nop, 1 activate, 2 read, 3 write, 4 precharge one, 5 precharge all, 6 refresh, 7 mode set) |
| req_bank | input | 2 | Target bank |
| req_row | input | 11 | Row address, or mode word for mode set |
| req_col | input | 8 | Column address |
| req_ap | input | 1 | Auto-precharge request for read or write |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 11 | Shared address bus |
| ba | output | 2 | Bank select |

## Verification
The hardest situation to reach is a field that a command must ignore. Many such fields carry values that would show up on the address bus if the placement logic leaked them. The stimulus table therefore loads every unused field with all-ones or a distinctive pattern: a full row on reads, a full column and a set flag on precharge and refresh, and a nonzero bank on precharge-all and mode set. The expected value in each case is zero in those positions. The table also walks back to back with no idle cycles, and a reset is asserted while a valid activate is held, so that the deselect pattern is seen to win over a pending request.

// File: rtl/sdram_fmt_pkg.sv
// Package: shared operation codes and pin command type for the formatter.
// Assumes the three-bit code space is fully used, so no illegal code exists.
package sdram_fmt_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ACT   = 3'd1,
        OP_RD    = 3'd2,
        OP_WR    = 3'd3,
        OP_PRE   = 3'd4,
        OP_PALL  = 3'd5,
        OP_REF   = 3'd6,
        OP_MSET  = 3'd7
    } fmt_op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam int CMD_W = 4;

    localparam pin_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam pin_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: maps an operation code to the four active-low command strobes.
// Assumes chip select is asserted for every command, including no-operation;
// an invalid request cycle is treated as a no-operation.
module sdram_cmd_decode
    import sdram_fmt_pkg::*;
(
    input  logic     valid,
    input  fmt_op_e  op,
    output pin_cmd_t cmd
);

    // Select the strobe pattern for the requested operation.
    always_comb begin
        cmd = CMD_NOP;
        if (valid) begin
            unique case (op)
                OP_NOP:  cmd = CMD_NOP;
                OP_ACT:  cmd = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
                OP_RD:   cmd = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
                OP_WR:   cmd = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
                OP_PRE:  cmd = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                OP_PALL: cmd = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                OP_REF:  cmd = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
                OP_MSET: cmd = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_addr_place.sv
// Module: places row, column, mode word and flags on the shared address
// lines and selects the bank bits for each operation.
// Assumes COL_W < AP_BIT < ADDR_W; unused bits are driven to zero.
module sdram_addr_place
    import sdram_fmt_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  logic              valid,
    input  fmt_op_e           op,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] row,
    input  logic [COL_W-1:0]  col,
    input  logic              ap,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    localparam int PAD_W = ADDR_W - COL_W;

    logic [ADDR_W-1:0] col_word;
    logic [ADDR_W-1:0] ap_mask;

    // Column zero-extended to bus width.
    assign col_word = {{PAD_W{1'b0}}, col};
    // Single-bit mask for the auto-precharge / all-banks line.
    assign ap_mask  = ADDR_W'(1) << AP_BIT;

    // Choose the address word and bank bits for the requested operation.
    always_comb begin
        addr = '0;
        ba   = '0;
        if (valid) begin
            unique case (op)
                OP_ACT: begin
                    addr = row;
                    ba   = bank;
                end
                OP_RD, OP_WR: begin
                    addr = col_word | (ap ? ap_mask : '0);
                    ba   = bank;
                end
                OP_PRE: begin
                    ba = bank;
                end
                OP_PALL: begin
                    addr = ap_mask;
                end
                OP_MSET: begin
                    addr = row;
                end
                default: begin
                    addr = '0;
                    ba   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdram_pin_reg.sv
// Module: output register stage with synchronous active-low reset to a
// parameter-given value. Assumes the caller packs all pins into one word.
module sdram_pin_reg #(
    parameter int           W       = 17,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the next pin word each rising edge, or load the reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

endmodule

// File: rtl/sdram_cmd_fmt.sv
// Module: top of the command and address formatter. Decodes each request into
// strobes and address placement, then registers every pin. Assumes the
// upstream controller has already met all inter-command timing.
module sdram_cmd_fmt
    import sdram_fmt_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    localparam int PIN_W = CMD_W + BANK_W + ADDR_W;
    localparam logic [PIN_W-1:0] PIN_RST = {CMD_DESEL, {BANK_W{1'b0}}, {ADDR_W{1'b0}}};

    fmt_op_e           op;
    logic              take;
    pin_cmd_t          cmd_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic [BANK_W-1:0] ba_nxt;
    logic [PIN_W-1:0]  pin_d;
    logic [PIN_W-1:0]  pin_q;
    logic              rdy_q;

    assign op   = fmt_op_e'(req_op);
    assign take = req_valid & rdy_q;

    sdram_cmd_decode u_dec (
        .valid (take),
        .op    (op),
        .cmd   (cmd_nxt)
    );

    sdram_addr_place #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .AP_BIT (AP_BIT)
    ) u_place (
        .valid (take),
        .op    (op),
        .bank  (req_bank),
        .row   (req_row),
        .col   (req_col),
        .ap    (req_ap),
        .addr  (addr_nxt),
        .ba    (ba_nxt)
    );

    assign pin_d = {cmd_nxt, ba_nxt, addr_nxt};

    sdram_pin_reg #(
        .W       (PIN_W),
        .RST_VAL (PIN_RST)
    ) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_d),
        .q     (pin_q)
    );

    // Ready rises on the first edge after reset release and then stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= 1'b1;
    end

    assign req_ready = rdy_q;
    assign {cs_n, ras_n, cas_n, we_n} = pin_q[PIN_W-1 -: CMD_W];
    assign ba   = pin_q[ADDR_W +: BANK_W];
    assign addr = pin_q[ADDR_W-1:0];

endmodule

// File: rtl/sdram_cmd_fmt_chk.sv
// Module: assertion checker for the formatter, bound to the top module.
// Assumes the top's default bit layout relationships (COL_W < AP_BIT).
module sdram_cmd_fmt_chk #(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic [BANK_W-1:0] req_bank,
    input logic [ADDR_W-1:0] req_row,
    input logic [COL_W-1:0]  req_col,
    input logic              req_ap,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] ba
);

    logic fire;
    assign fire = req_valid && req_ready;

    AST_RESET_DESELECT: assert property (@(posedge clk)
        !rst_n |=> (cs_n && ras_n && cas_n && we_n && addr == '0 && ba == '0 && !req_ready)); // R1

    AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!cs_n && ras_n && cas_n && we_n && addr == '0 && ba == '0)); // R2

    AST_ACT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 3'd1) |=> (!ras_n && cas_n && we_n && addr == $past(req_row) && ba == $past(req_bank))); // R3

    AST_READ_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 3'd2) |=> (ras_n && !cas_n && we_n && addr[COL_W-1:0] == $past(req_col)
                                      && addr[AP_BIT] == $past(req_ap) && addr[AP_BIT-1:COL_W] == '0)); // R4

    AST_WRITE_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 3'd3) |=> (ras_n && !cas_n && !we_n && addr[COL_W-1:0] == $past(req_col)
                                      && ba == $past(req_bank))); // R5

    AST_PRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 3'd4) |=> (!ras_n && cas_n && !we_n && !addr[AP_BIT] && ba == $past(req_bank))); // R6

    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 3'd5) |=> (!ras_n && cas_n && !we_n && $countones(addr) == 1 && addr[AP_BIT] && ba == '0)); // R7

    AST_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 3'd6) |=> (!ras_n && !cas_n && we_n && addr == '0 && ba == '0)); // R8

    AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 3'd7) |=> (!cs_n && !ras_n && !cas_n && !we_n && addr == $past(req_row) && ba == '0)); // R9

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> req_ready); // R10

endmodule

bind sdram_cmd_fmt sdram_cmd_fmt_chk #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .AP_BIT (AP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_ap    (req_ap),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba)
);

// File: tb/sdram_cmd_fmt_test.sv
`timescale 1ns/100ps
module sdram_cmd_fmt_test;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  bank;
        logic [10:0] row;
        logic [7:0]  col;
        logic        ap;
        logic [16:0] exp;   // {cs,ras,cas,we, ba[1:0], addr[10:0]}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R3 with R11: column and flag ignored on activate
        '{3'd1, 2'd2, 11'h5A3, 8'hFF, 1'b1, {4'b0011, 2'd2, 11'h5A3}, 4'd3},
        '{3'd1, 2'd0, 11'h7FF, 8'h00, 1'b0, {4'b0011, 2'd0, 11'h7FF}, 4'd3},
        // R4 with R11: row ignored on read
        '{3'd2, 2'd1, 11'h7FF, 8'h3C, 1'b0, {4'b0101, 2'd1, 11'h03C}, 4'd11},
        '{3'd2, 2'd3, 11'h000, 8'hA5, 1'b1, {4'b0101, 2'd3, 11'h4A5}, 4'd4},
        // R5 write
        '{3'd3, 2'd2, 11'h155, 8'h81, 1'b0, {4'b0100, 2'd2, 11'h081}, 4'd5},
        '{3'd3, 2'd0, 11'h7FF, 8'hFF, 1'b1, {4'b0100, 2'd0, 11'h4FF}, 4'd5},
        // R6 precharge one bank, flag/row/col ignored
        '{3'd4, 2'd3, 11'h7FF, 8'hFF, 1'b1, {4'b0010, 2'd3, 11'h000}, 4'd6},
        // R7 precharge all, bank and row ignored
        '{3'd5, 2'd2, 11'h123, 8'h55, 1'b0, {4'b0010, 2'd0, 11'h400}, 4'd7},
        // R8 refresh, all fields ignored
        '{3'd6, 2'd1, 11'h7FF, 8'hFF, 1'b1, {4'b0001, 2'd0, 11'h000}, 4'd8},
        // R9 mode set
        '{3'd7, 2'd3, 11'h032, 8'hFF, 1'b1, {4'b0000, 2'd0, 11'h032}, 4'd9},
        '{3'd7, 2'd0, 11'h7FF, 8'h00, 1'b0, {4'b0000, 2'd0, 11'h7FF}, 4'd9},
        // R2 valid no-operation with busy fields
        '{3'd0, 2'd3, 11'h7FF, 8'hFF, 1'b1, {4'b0111, 2'd0, 11'h000}, 4'd2},
        // R10 back to back after no-operation
        '{3'd1, 2'd1, 11'h001, 8'h00, 1'b0, {4'b0011, 2'd1, 11'h001}, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_bank = '0;
    logic [10:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic        req_ap = 1'b0;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [10:0] addr;
    logic [1:0]  ba;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_fmt uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ap(req_ap), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba)
    );

    function automatic logic [16:0] pins();
        return {cs_n, ras_n, cas_n, we_n, ba, addr};
    endfunction

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pins actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] b,
                         input logic [10:0] r, input logic [7:0] c, input logic a);
        req_valid = v; req_op = op; req_bank = b; req_row = r; req_col = c; req_ap = a;
    endtask

    localparam logic [16:0] DESEL = {4'b1111, 2'd0, 11'h000};
    localparam logic [16:0] NOP   = {4'b0111, 2'd0, 11'h000};

    initial begin
        // R1: reset state, with a valid request held
        drive(1'b1, 3'd1, 2'd3, 11'h7FF, 8'hFF, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", pins(), DESEL);
        chk1("R1", req_ready, 1'b0);
        @(negedge clk);
        drive(1'b0, 3'd0, 2'd0, 11'h0, 8'h0, 1'b0);
        rst_n = 1'b1;
        // R2 / R10: first edge after release gives idle NOP and ready
        @(posedge clk); #1;
        chk("R2", pins(), NOP);
        chk1("R10", req_ready, 1'b1);

        // Table walk, one request per cycle (R10 back to back)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VECS[i].op, VECS[i].bank, VECS[i].row, VECS[i].col, VECS[i].ap);
            @(posedge clk); #1;
            chk($sformatf("R%0d vec %0d", VECS[i].req, i), pins(), VECS[i].exp);
        end

        // R2 / R10: valid drops, NOP follows on the very next cycle
        @(negedge clk);
        drive(1'b0, 3'd7, 2'd3, 11'h7FF, 8'hFF, 1'b1);
        @(posedge clk); #1;
        chk("R2 idle after burst", pins(), NOP);
        @(posedge clk); #1;
        chk("R2 idle hold", pins(), NOP);

        // R1: reset mid-run while an activate is valid
        @(negedge clk);
        drive(1'b1, 3'd1, 2'd1, 11'h2AA, 8'h00, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid-run", pins(), DESEL);
        chk1("R1 ready mid-run", req_ready, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: request held through release is not taken while ready is low
        @(posedge clk); #1;
        chk("R10 not ready", pins(), NOP);
        @(posedge clk); #1;
        chk("R3 after ready", pins(), {4'b0011, 2'd1, 11'h2AA});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule